// File: doc/BRIEF.md
# TDM Frame Deserializer and Demultiplexer

This block sits at the receiving end of a serial link that carries four sampled channels over one bitstream. The bit clock comes with the data on its own wire, so every rising edge of `clk` delivers exactly one line bit on `rx_bit`. Each frame is 33 bits long: one alignment bit, then 32 payload bits. The payload interleaves the four channels one bit at a time. The most significant bits come first, and within each bit position channel 0 comes first.

The receiver does not know where a frame starts. It picks a candidate slot and watches the bit in that slot from frame to frame. The alignment bit flips on every frame, so a candidate whose bit keeps flipping is taken as the frame start. A candidate whose bit stays the same is rejected, and the search moves one bit later. Once aligned, the block keeps checking the alignment bit and gives up after repeated failures. For each complete aligned frame it shifts the payload into four 8-bit words. It presents all four words at once with a one-cycle strobe, ready for parallel-input digital-to-analog converters.

Top module: `tdm_frame_demux`

## Requirements
- R1: A frame is 33 bit slots. Slot 0 carries the alignment bit and slots 1 to 32 carry payload. Payload slot 1+k (k = 0..31) carries bit 7 - k/4 (integer division) of channel k mod 4. Channel c is output on `samples_o[8c+7:8c]`.
- R2: While searching, the first candidate alignment bit becomes a reference. `locked_o` goes high in the cycle after the candidate slot has shown the inverse of the previous candidate bit four frames in a row. After only three such flips it stays low.
- R3: While searching, if a candidate bit equals the previous candidate bit, the candidate position moves one bit later. The bit right after the rejected candidate becomes the new reference, and the flip count restarts.
- R4: While locked, the expected alignment bit inverts every frame, even in a frame where it was not seen. A single mismatch keeps `locked_o` high, and a matching frame clears the mismatch count.
- R5: Two consecutive alignment mismatches while locked drop `locked_o` in the cycle after the second one. The search then restarts one bit later.
- R6: `update_o` is high for exactly one cycle: the cycle after the last payload bit of a frame whose payload arrived while `locked_o` was high. All four words change in that same cycle.
- R7: `samples_o` holds its value in every cycle without `update_o`. While `locked_o` is low, `update_o` stays low.
- R8: A synchronous active-high reset clears `samples_o`, `update_o` and `locked_o`. The first bit after reset is the first alignment candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock delivered alongside the data; one line bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial line bit |
| samples_o | output | 32 | Four 8-bit words; channel c at bits 8c+7..8c |
| update_o | output | 1 | One-cycle strobe when all four words take new values |
| locked_o | output | 1 | High while frame alignment is established |

## Verification
The bench goes after these corner cases:
- **Lock after four flips, not three.** A design that locks one frame early delivers a frame before alignment is confirmed.
- **A stream offset by one bit.** The only way to reach alignment is to slip once. A design that searches without slipping never locks, or locks on a payload bit.
- **Mismatch counting.** Two isolated mismatches separated by a good frame must not cost the lock, but two in a row must. A design that never clears its mismatch count drops lock too early. One that ignores mismatches never drops it.
- **After lock is lost.** The bench checks that the words hold and no strobe appears, which exposes a design that keeps delivering stale or misaligned frames.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } align_state_e;

    typedef struct packed {
        logic is_sync;
        logic is_last;
    } slot_flags_t;

    function automatic int unsigned frame_len(input int unsigned n_src,
                                              input int unsigned sample_w);
        return n_src * sample_w + 1;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
    import tdm_rx_pkg::*;
#(
    parameter int unsigned FRAME_LEN = 33,
    localparam int unsigned SLOT_W = width_of(FRAME_LEN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slip_i,
    output logic [SLOT_W-1:0] slot_o,
    output slot_flags_t       flags_o
);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FRAME_LEN - 1);

    logic [SLOT_W-1:0] slot_q;

    // A slip keeps the counter on the sync slot for one more bit, so the
    // frame phase moves one position later.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= '0;
        end else if (slip_i) begin
            slot_q <= '0;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    always_comb begin
        flags_o.is_sync = (slot_q == '0);
        flags_o.is_last = (slot_q == LAST_SLOT);
    end

    assign slot_o = slot_q;

endmodule

// File: rtl/tdm_sync_lock.sv
module tdm_sync_lock
    import tdm_rx_pkg::*;
#(
    parameter int unsigned LOCK_TOGGLES = 4,
    parameter int unsigned LOSS_MISSES  = 2,
    localparam int unsigned TW = width_of(LOCK_TOGGLES + 1),
    localparam int unsigned MW = width_of(LOSS_MISSES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_slot_i,
    input  logic bit_i,
    output logic locked_o,
    output logic slip_o
);
    localparam logic [TW-1:0] TOG_LAST  = TW'(LOCK_TOGGLES - 1);
    localparam logic [MW-1:0] MISS_LAST = MW'(LOSS_MISSES - 1);

    align_state_e  state_q;
    logic          have_ref_q;
    logic          ref_q;
    logic [TW-1:0] tog_cnt_q;
    logic [MW-1:0] miss_cnt_q;
    logic          toggled;

    assign toggled = (bit_i != ref_q);

    always_comb begin
        slip_o = 1'b0;
        if (sync_slot_i) begin
            if (state_q == ST_HUNT) begin
                slip_o = have_ref_q && !toggled;
            end else begin
                slip_o = !toggled && (miss_cnt_q == MISS_LAST);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_HUNT;
            have_ref_q <= 1'b0;
            ref_q      <= 1'b0;
            tog_cnt_q  <= '0;
            miss_cnt_q <= '0;
        end else if (sync_slot_i) begin
            if (state_q == ST_HUNT) begin
                if (!have_ref_q) begin
                    have_ref_q <= 1'b1;
                    ref_q      <= bit_i;
                    tog_cnt_q  <= '0;
                end else if (toggled) begin
                    ref_q <= bit_i;
                    if (tog_cnt_q == TOG_LAST) begin
                        state_q    <= ST_LOCK;
                        miss_cnt_q <= '0;
                        tog_cnt_q  <= '0;
                    end else begin
                        tog_cnt_q <= tog_cnt_q + TW'(1);
                    end
                end else begin
                    have_ref_q <= 1'b0;
                    tog_cnt_q  <= '0;
                end
            end else begin
                // The expected value flips every frame whether or not it matched.
                ref_q <= ~ref_q;
                if (toggled) begin
                    miss_cnt_q <= '0;
                end else if (miss_cnt_q == MISS_LAST) begin
                    state_q    <= ST_HUNT;
                    have_ref_q <= 1'b0;
                    tog_cnt_q  <= '0;
                    miss_cnt_q <= '0;
                end else begin
                    miss_cnt_q <= miss_cnt_q + MW'(1);
                end
            end
        end
    end

    assign locked_o = (state_q == ST_LOCK);

endmodule

// File: rtl/tdm_lane_assembler.sv
module tdm_lane_assembler
    import tdm_rx_pkg::*;
#(
    parameter int unsigned N_SRC    = 4,
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned SLOT_W   = 6,
    localparam int unsigned LANE_W  = width_of(N_SRC)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [SLOT_W-1:0]         slot_i,
    input  slot_flags_t               flags_i,
    input  logic                      bit_i,
    input  logic                      locked_i,
    output logic [N_SRC*SAMPLE_W-1:0] samples_o,
    output logic                      update_o
);
    logic [SLOT_W-1:0]         pay_idx;
    logic [LANE_W-1:0]         lane_sel;
    logic [N_SRC*SAMPLE_W-1:0] next_word;
    logic                      commit;

    assign pay_idx  = slot_i - SLOT_W'(1);
    assign lane_sel = LANE_W'(pay_idx % SLOT_W'(N_SRC));
    assign commit   = flags_i.is_last && locked_i;

    for (genvar l = 0; l < N_SRC; l++) begin : g_lane
        logic [SAMPLE_W-1:0] shreg_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                shreg_q <= '0;
            end else if (!flags_i.is_sync && lane_sel == LANE_W'(l)) begin
                shreg_q <= {shreg_q[SAMPLE_W-2:0], bit_i};
            end
        end

        if (l == N_SRC - 1) begin : g_tail
            // The last lane takes its LSB in the same slot the frame is committed.
            assign next_word[l*SAMPLE_W +: SAMPLE_W] = {shreg_q[SAMPLE_W-2:0], bit_i};
        end else begin : g_body
            assign next_word[l*SAMPLE_W +: SAMPLE_W] = shreg_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            samples_o <= '0;
            update_o  <= 1'b0;
        end else begin
            update_o <= commit;
            if (commit) begin
                samples_o <= next_word;
            end
        end
    end

endmodule

// File: rtl/tdm_frame_demux.sv
module tdm_frame_demux
    import tdm_rx_pkg::*;
#(
    parameter int unsigned N_SRC        = 4,
    parameter int unsigned SAMPLE_W     = 8,
    parameter int unsigned LOCK_TOGGLES = 4,
    parameter int unsigned LOSS_MISSES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      rx_bit,
    output logic [N_SRC*SAMPLE_W-1:0] samples_o,
    output logic                      update_o,
    output logic                      locked_o
);
    localparam int unsigned FRAME_LEN = frame_len(N_SRC, SAMPLE_W);
    localparam int unsigned SLOT_W    = width_of(FRAME_LEN);

    logic [SLOT_W-1:0] slot_q;
    slot_flags_t       flags;
    logic              slip;
    logic              locked;

    tdm_slot_seq #(
        .FRAME_LEN(FRAME_LEN)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .slip_i (slip),
        .slot_o (slot_q),
        .flags_o(flags)
    );

    tdm_sync_lock #(
        .LOCK_TOGGLES(LOCK_TOGGLES),
        .LOSS_MISSES (LOSS_MISSES)
    ) u_lock (
        .clk        (clk),
        .rst        (rst),
        .sync_slot_i(flags.is_sync),
        .bit_i      (rx_bit),
        .locked_o   (locked),
        .slip_o     (slip)
    );

    tdm_lane_assembler #(
        .N_SRC   (N_SRC),
        .SAMPLE_W(SAMPLE_W),
        .SLOT_W  (SLOT_W)
    ) u_asm (
        .clk      (clk),
        .rst      (rst),
        .slot_i   (slot_q),
        .flags_i  (flags),
        .bit_i    (rx_bit),
        .locked_i (locked),
        .samples_o(samples_o),
        .update_o (update_o)
    );

    assign locked_o = locked;

endmodule

// File: rtl/tdm_frame_demux_chk.sv
module tdm_frame_demux_chk #(
    parameter int unsigned N_SRC    = 4,
    parameter int unsigned SAMPLE_W = 8,
    parameter int unsigned SLOT_W   = 6,
    parameter int unsigned LAST     = 32
) (
    input logic                      clk,
    input logic                      rst,
    input logic [SLOT_W-1:0]         slot,
    input logic                      locked,
    input logic                      update,
    input logic [N_SRC*SAMPLE_W-1:0] samples
);
    a_r1_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        slot <= SLOT_W'(LAST));

    a_r2_lock_rises_at_sync: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(slot) == '0);

    a_r5_lock_falls_at_sync: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(slot) == '0);

    a_r6_update_needs_lock: assert property (@(posedge clk) disable iff (rst)
        update |-> $past(locked));

    a_r6_update_at_frame_end: assert property (@(posedge clk) disable iff (rst)
        update |-> $past(slot) == SLOT_W'(LAST));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        update |=> !update);

    a_r7_hold_between_updates: assert property (@(posedge clk) disable iff (rst)
        !update |-> $stable(samples));

endmodule

bind tdm_frame_demux tdm_frame_demux_chk #(
    .N_SRC   (N_SRC),
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W),
    .LAST    (FRAME_LEN - 1)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .slot   (slot_q),
    .locked (locked_o),
    .update (update_o),
    .samples(samples_o)
);

// File: tb/tb_tdm_frame_demux.sv
module tb_tdm_frame_demux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rx_bit = 1'b0;
    logic [31:0] samples;
    logic        upd;
    logic        locked;

    int          checks = 0;
    int          fails = 0;
    logic [31:0] last_out = '0;
    logic        exp_sync;

    always #5 clk = ~clk;

    tdm_frame_demux dut (
        .clk      (clk),
        .rst      (rst),
        .rx_bit   (rx_bit),
        .samples_o(samples),
        .update_o (upd),
        .locked_o (locked)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic ser_bit(input logic [31:0] w, input int k);
        return w[(k % 4) * 8 + (7 - k / 4)];
    endfunction

    task automatic send_bit(input logic b);
        rx_bit = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(samples == '0, "R8", "samples after reset", samples, '0);
        check(upd == 1'b0, "R8", "update after reset", {31'b0, upd}, '0);
        check(locked == 1'b0, "R8", "locked after reset", {31'b0, locked}, '0);
        last_out = '0;
        rst = 1'b0;
    endtask

    // Sends one frame; checks the strobe only at frame end and the held/new words.
    task automatic send_frame(input logic s, input logic [31:0] w, input bit exp_upd,
                              input bit exp_lock, input string req);
        int early = 0;
        send_bit(s);
        if (upd) early++;
        for (int k = 0; k < 32; k++) begin
            send_bit(ser_bit(w, k));
            if (k < 31 && upd) early++;
        end
        check(early == 0, "R6", "strobe inside frame", early, 0);
        check(upd == exp_upd, req, "update at frame end", {31'b0, upd}, {31'b0, exp_upd});
        if (exp_upd) begin
            check(samples == w, "R1", "delivered words", samples, w);
            last_out = w;
        end else begin
            check(samples == last_out, "R7", "words held", samples, last_out);
        end
        check(locked == exp_lock, req, "locked at frame end", {31'b0, locked}, {31'b0, exp_lock});
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] w;
        void'($urandom(32'h5EED_0413));
        #1;
        do_reset();

        // Aligned start: reference + 3 flips stays unlocked, 4th flip locks (R2).
        exp_sync = 1'b0;
        for (int f = 0; f < 4; f++) begin
            send_frame(exp_sync, $urandom(), 1'b0, 1'b0, "R2");
            exp_sync = ~exp_sync;
        end
        w = $urandom();
        send_frame(exp_sync, w, 1'b1, 1'b1, "R2");
        exp_sync = ~exp_sync;

        // Random payloads while locked (R1, R6).
        for (int f = 0; f < 12; f++) begin
            send_frame(exp_sync, $urandom(), 1'b1, 1'b1, "R6");
            exp_sync = ~exp_sync;
        end
        // Directed patterns for bit ordering (R1).
        send_frame(exp_sync, 32'h0000_0080, 1'b1, 1'b1, "R1");
        exp_sync = ~exp_sync;
        send_frame(exp_sync, 32'h0100_0000, 1'b1, 1'b1, "R1");
        exp_sync = ~exp_sync;
        send_frame(exp_sync, 32'hA55A_F00F, 1'b1, 1'b1, "R1");
        exp_sync = ~exp_sync;

        // Isolated single misses keep lock; a good frame clears the count (R4).
        send_frame(~exp_sync, $urandom(), 1'b1, 1'b1, "R4");
        exp_sync = ~exp_sync;
        send_frame(exp_sync, $urandom(), 1'b1, 1'b1, "R4");
        exp_sync = ~exp_sync;
        send_frame(~exp_sync, $urandom(), 1'b1, 1'b1, "R4");
        exp_sync = ~exp_sync;
        send_frame(exp_sync, $urandom(), 1'b1, 1'b1, "R4");
        exp_sync = ~exp_sync;

        // Two consecutive misses: lock drops, that frame is not delivered (R5, R7).
        send_frame(~exp_sync, $urandom(), 1'b1, 1'b1, "R5");
        exp_sync = ~exp_sync;
        send_frame(~exp_sync, $urandom(), 1'b0, 1'b0, "R5");
        exp_sync = ~exp_sync;
        send_frame(exp_sync, $urandom(), 1'b0, 1'b0, "R7");

        // Reset from a delivered state clears the words (R8).
        do_reset();

        // Stream offset by one bit: only a single slip reaches alignment (R3).
        send_bit(1'b0);
        w = $urandom() & 32'hFEFF_FFFF;   // slot 32 carries channel 3 bit 0 = 0
        send_frame(1'b1, w, 1'b0, 1'b0, "R3");
        exp_sync = 1'b1;
        for (int f = 1; f < 5; f++) begin
            send_frame(exp_sync, $urandom(), 1'b0, 1'b0, "R3");
            exp_sync = ~exp_sync;
        end
        send_frame(exp_sync, $urandom(), 1'b1, 1'b1, "R3");
        exp_sync = ~exp_sync;
        for (int f = 0; f < 8; f++) begin
            send_frame(exp_sync, $urandom(), 1'b1, 1'b1, "R1");
            exp_sync = ~exp_sync;
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule